// File: doc/BRIEF.md
# Key-Protected System Control Register File

This block is a bank of 32-bit configuration words for chip-level control, reached through a simple single-cycle word bus. Each access has an enable, a write flag, a byte address and write data. Reads return their data one cycle later on a registered output. A one-cycle error pulse flags any access that the block refuses or that is not allowed.

A key register gates a fixed low window of the map. Writes into that window are dropped until the magic key has been written. A few status words are read-only. One strap word can only gain bits on the newer chip variant, and it loses bits through writes to the revision word. A random-data word yields a new pseudo-random value on every read. After reset, the words hold constants that depend on the variant, and the revision, both strap words and the key word take the values present on input ports.

Top module: `scb_regfile`

## Requirements
- R1: The word index is the byte address divided by 4, in a 4 KiB window. An access whose two low address bits are not zero has no effect. If it is a read it returns 0, and it raises the error pulse.
- R2: A write to offset 0x000 stores 1 when the data equals KEY_MAGIC (default 0x5CA1AB1E) and stores 0 for any other data. This write is accepted even while the bank is locked.
- R3: While the key word reads 0, writes to offsets 0x004 through 0x100 are dropped and raise the error pulse. Offsets 0x104 and above stay writable.
- R4: Writes to offsets 0x014, 0x050–0x06C, 0x078, 0x0E0 and 0x0E4 leave those words unchanged and raise the error pulse.
- R5: A write to the strap word at 0x070 ORs the data into it when variant_new_i is 1. It replaces the word when variant_new_i is 0.
- R6: A write to the revision word at 0x07C never changes that word. When variant_new_i is 1, it clears the strap-word bits that are set in the data. When variant_new_i is 0, it changes nothing and raises the error pulse.
- R7: Each read of 0x078 first advances a Galois LFSR and then returns the new state. The step is next = (s >> 1) ^ (s[0] ? RNG_POLY : 0), with defaults RNG_POLY = 0x80200003 and reset state RNG_SEED = 0xACE10001. The enable bits written to 0x074 have no effect on this.
- R8: After reset, 0x004 = 0xFFCFFEDC, 0x024 = 0x00000291 (old variant) or 0x93000400 (new variant), 0x09C = 0x003FFFF3 (old) or 0x023FFFF3 (new), 0x1A4 = 0x00002402 and 0x100 = 0. The words at 0x000, 0x070, 0x0D0 and 0x07C hold key_i, strap1_i, strap2_i and rev_i.
- R9: The array holds NUM_REGS (106) words. A read at offset 0x1A8 or beyond returns 0, a write there is dropped, and both raise the error pulse.
- R10: A read of the wake-up word at 0x0C0 returns its stored value and raises the error pulse.
- R11: Read data and the error pulse appear on the first rising edge after the access. The error is high for exactly that one cycle. Read data holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_new_i | input | 1 | 1 selects the newer chip variant |
| strap1_i | input | 32 | Reset value of the strap word at 0x070 |
| strap2_i | input | 32 | Reset value of the second strap word at 0x0D0 |
| rev_i | input | 32 | Value of the revision word at 0x07C |
| key_i | input | 32 | Reset value of the key word at 0x000 |
| acc_en_i | input | 1 | Access request this cycle |
| acc_wr_i | input | 1 | 1 write, 0 read |
| acc_addr_i | input | 12 | Byte address |
| acc_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle error pulse for refused or illegal accesses |

## Verification
A wrong lock state shows at the ports on the very next access into the window: the error pulse appears where it should not, or fails to appear, one cycle after the write. A later read back of the word then shows that the data was either stored or dropped when the opposite was expected. A corrupted strap or LFSR state only shows when that word is read. For this reason the bench reads these words often, between random writes, and compares every read against a model that steps the LFSR itself. Because every access checks the error pulse one cycle later, a misclassified offset is caught on its first use.

// File: rtl/scb_pkg.sv
package scb_pkg;

  typedef enum logic [2:0] {
    K_PLAIN,
    K_KEY,
    K_STRAP,
    K_REV,
    K_RNG,
    K_RO,
    K_WAKE
  } reg_kind_e;

  // word indices whose behaviour is fixed by the map
  localparam int unsigned IDX_KEY      = 0;
  localparam int unsigned IDX_STRAP1   = 28;   // 0x070
  localparam int unsigned IDX_RNGCTL   = 29;   // 0x074
  localparam int unsigned IDX_RNG      = 30;   // 0x078
  localparam int unsigned IDX_REV      = 31;   // 0x07C
  localparam int unsigned IDX_WAKE     = 48;   // 0x0C0
  localparam int unsigned IDX_STRAP2   = 52;   // 0x0D0
  localparam int unsigned IDX_LOCK_END = 65;   // 0x104, first index outside lock window

  function automatic reg_kind_e kind_of(input int unsigned idx);
    reg_kind_e k;
    k = K_PLAIN;
    if (idx == IDX_KEY)                        k = K_KEY;
    else if (idx == IDX_STRAP1)                k = K_STRAP;
    else if (idx == IDX_REV)                   k = K_REV;
    else if (idx == IDX_RNG)                   k = K_RNG;
    else if (idx == IDX_WAKE)                  k = K_WAKE;
    else if (idx == 5 || (idx >= 20 && idx <= 27) ||
             idx == 56 || idx == 57)           k = K_RO;
    return k;
  endfunction

  // per-variant reset constants, unlisted words clear to zero
  function automatic logic [31:0] reset_word(input int unsigned idx, input logic newer);
    logic [31:0] v;
    case (idx)
      1:       v = 32'hFFCF_FEDC;
      2:       v = 32'hF3F4_0000;
      3:       v = 32'h19FC_3E8B;
      7:       v = 32'h0002_6108;
      8:       v = 32'h0003_0291;
      9:       v = newer ? 32'h9300_0400 : 32'h0000_0291;
      11:      v = 32'h0000_0010;
      12, 13:  v = 32'h2000_1A03;
      14:      v = 32'h0400_0030;
      15:      v = 32'h0000_0001;
      16:      v = 32'h0000_00C0;
      19:      v = 32'h0000_0023;
      29:      v = 32'h0000_000E;
      33:      v = 32'h0000_F000;
      34:      v = newer ? 32'h0300_0000 : 32'h0100_0000;
      35:      v = newer ? 32'h0000_0000 : 32'h0000_00FF;
      36:      v = 32'h0000_A000;
      39:      v = newer ? 32'h023F_FFF3 : 32'h003F_FFF3;
      41:      v = 32'hFFFF_0000;
      42:      v = 32'h000F_FFFF;
      56, 57:  v = 32'h0000_00FF;
      65:      v = 32'h8000_0000;
      68:      v = 32'h1E60_0000;
      69:      v = 32'hC000_0000;
      88:      v = 32'h0000_1903;
      96:      v = 32'h0000_007B;
      105:     v = 32'h0000_2402;
      default: v = 32'h0000_0000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/scb_decode.sv
module scb_decode
  import scb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 106,
  localparam int unsigned FULL_W  = ADDR_W - 2,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              locked_i,
  input  logic              newer_i,
  output logic [IDX_W-1:0]  idx_o,
  output reg_kind_e         kind_o,
  output logic              wr_ok_o,
  output logic              rd_ok_o,
  output logic              err_o
);

  localparam logic [FULL_W-1:0] LIMIT    = FULL_W'(NUM_REGS);
  localparam logic [FULL_W-1:0] LOCK_END = FULL_W'(IDX_LOCK_END);

  logic [FULL_W-1:0] full_idx;
  logic              aligned;
  logic              in_range;
  logic              in_lock_win;
  logic              refused;

  always_comb begin
    full_idx    = addr_i[ADDR_W-1:2];
    aligned     = (addr_i[1:0] == 2'b00);
    in_range    = aligned && (full_idx < LIMIT);
    idx_o       = addr_i[IDX_W+1:2];
    kind_o      = in_range ? kind_of(int'(full_idx)) : K_PLAIN;
    in_lock_win = (full_idx != '0) && (full_idx < LOCK_END);
    refused     = (locked_i && in_lock_win) ||
                  (kind_o == K_RO) || (kind_o == K_RNG) ||
                  (kind_o == K_REV && !newer_i);
    wr_ok_o     = en_i && wr_i && in_range && !refused;
    rd_ok_o     = en_i && !wr_i && in_range;
    err_o       = en_i && (!in_range ||
                           (wr_i && refused) ||
                           (!wr_i && kind_o == K_WAKE));
  end

endmodule

// File: rtl/scb_lfsr.sv
module scb_lfsr #(
  parameter int unsigned   W    = 32,
  parameter logic [W-1:0]  POLY = 32'h8020_0003,
  parameter logic [W-1:0]  SEED = 32'hACE1_0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] state_o,
  output logic [W-1:0] next_o
);

  logic [W-1:0] state_q;

  always_comb begin
    next_o = (state_q >> 1) ^ (state_q[0] ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= SEED;
    else if (adv_i) state_q <= next_o;
  end

  assign state_o = state_q;

  // R7: every advance moves the generator to a different state
  p_rng_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (state_q != $past(state_q)));

endmodule

// File: rtl/scb_regfile.sv
module scb_regfile
  import scb_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 12,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       NUM_REGS  = 106,
  parameter logic [DATA_W-1:0] KEY_MAGIC = 32'h5CA1_AB1E,
  parameter logic [DATA_W-1:0] RNG_POLY  = 32'h8020_0003,
  parameter logic [DATA_W-1:0] RNG_SEED  = 32'hACE1_0001,
  localparam int unsigned      IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              variant_new_i,
  input  logic [DATA_W-1:0] strap1_i,
  input  logic [DATA_W-1:0] strap2_i,
  input  logic [DATA_W-1:0] rev_i,
  input  logic [DATA_W-1:0] key_i,
  input  logic              acc_en_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_o
);

  localparam logic [ADDR_W-1:0] A_WIN   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_RO    = ADDR_W'(5 * 4);
  localparam logic [ADDR_W-1:0] A_STRAP = ADDR_W'(IDX_STRAP1 * 4);
  localparam logic [ADDR_W-1:0] A_REV   = ADDR_W'(IDX_REV * 4);
  localparam logic [ADDR_W-1:0] A_WAKE  = ADDR_W'(IDX_WAKE * 4);
  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(NUM_REGS * 4);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [IDX_W-1:0]  idx;
  reg_kind_e         kind;
  logic              wr_ok, rd_ok, err_d, locked;
  logic              hit_rev;
  logic [DATA_W-1:0] rng_state, rng_next;
  logic [DATA_W-1:0] rd_d, rd_q;
  logic              rd_en, err_q;

  assign locked  = (regs_q[IDX_KEY] == '0);
  assign hit_rev = wr_ok && (idx == IDX_W'(IDX_REV));

  scb_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_dec (
    .en_i     (acc_en_i),
    .wr_i     (acc_wr_i),
    .addr_i   (acc_addr_i),
    .locked_i (locked),
    .newer_i  (variant_new_i),
    .idx_o    (idx),
    .kind_o   (kind),
    .wr_ok_o  (wr_ok),
    .rd_ok_o  (rd_ok),
    .err_o    (err_d)
  );

  scb_lfsr #(
    .W    (DATA_W),
    .POLY (RNG_POLY),
    .SEED (RNG_SEED)
  ) u_rng (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (rd_ok && kind == K_RNG),
    .state_o (rng_state),
    .next_o  (rng_next)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == IDX_RNG) begin : g_rng
      assign regs_q[g] = rng_state;
    end else if (g == IDX_REV) begin : g_rev
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= rev_i;
        else        q <= q;
      end
      assign regs_q[g] = q;
    end else begin : g_ff
      logic [DATA_W-1:0] q, d, rv;
      logic              hit, en;
      assign hit = wr_ok && (idx == IDX_W'(g));
      if (g == IDX_KEY) begin : g_key
        assign rv = key_i;
        always_comb begin
          en = hit;
          d  = (acc_wdata_i == KEY_MAGIC) ? DATA_W'(1) : '0;
        end
      end else if (g == IDX_STRAP1) begin : g_strap
        assign rv = strap1_i;
        always_comb begin
          en = hit || hit_rev;
          if (hit_rev)            d = q & ~acc_wdata_i;
          else if (variant_new_i) d = q | acc_wdata_i;
          else                    d = acc_wdata_i;
        end
      end else begin : g_plain
        if (g == IDX_STRAP2) begin : g_rv_port
          assign rv = strap2_i;
        end else begin : g_rv_const
          assign rv = DATA_W'(reset_word(g, variant_new_i));
        end
        always_comb begin
          en = hit;
          d  = acc_wdata_i;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= rv;
        else if (en) q <= d;
      end
      assign regs_q[g] = q;
    end
  end

  // read path: value captured on the access edge
  always_comb begin
    rd_en = acc_en_i && !acc_wr_i;
    if (!rd_ok)             rd_d = '0;
    else if (kind == K_RNG) rd_d = rng_next;
    else                    rd_d = regs_q[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign rd_data_o = rd_q;
  assign err_o     = err_q;

  // R2: key word only ever takes 0 or 1 through a write
  p_key_bool_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && acc_wr_i && acc_addr_i == '0) |=> (regs_q[IDX_KEY] <= DATA_W'(1)));

  // R3: locked window write is dropped and flagged
  p_lock_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && acc_wr_i && acc_addr_i == A_WIN && regs_q[IDX_KEY] == '0)
    |=> ($stable(regs_q[2]) && err_o));

  // R4: read-only word keeps its value
  p_ro_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && acc_wr_i && acc_addr_i == A_RO) |=> ($stable(regs_q[5]) && err_o));

  // R5: on the newer variant the strap write only adds bits
  p_strap_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && acc_wr_i && acc_addr_i == A_STRAP && variant_new_i &&
     regs_q[IDX_KEY] != '0)
    |=> ((regs_q[IDX_STRAP1] & $past(acc_wdata_i)) == $past(acc_wdata_i)));

  // R6: revision word survives a write to it
  p_rev_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && acc_wr_i && acc_addr_i == A_REV) |=> $stable(regs_q[IDX_REV]));

  // R9: reads past the array return zero with an error
  p_oor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && !acc_wr_i && acc_addr_i >= A_LIMIT) |=> (rd_data_o == '0 && err_o));

  // R10: wake-up word read is flagged
  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && !acc_wr_i && acc_addr_i == A_WAKE) |=> err_o);

  // R11: no error pulse without an access the cycle before
  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en_i |=> !err_o);

endmodule

// File: tb/scb_regfile_test.sv
`timescale 1ns/1ps
module scb_regfile_test;

  localparam logic [31:0] MAGIC = 32'h5CA1_AB1E;
  localparam logic [31:0] POLY  = 32'h8020_0003;
  localparam logic [31:0] SEED  = 32'hACE1_0001;
  localparam int          NREG  = 106;

  logic        clk, rst_n, newer;
  logic [31:0] strap1, strap2, rev, key;
  logic        en, wr;
  logic [11:0] addr;
  logic [31:0] wdata, rd_data;
  logic        err;

  int          n_tests, n_fail;
  logic [31:0] m [NREG];
  logic [31:0] rng_m;
  logic [31:0] last_rd;

  scb_regfile #(
    .KEY_MAGIC (MAGIC),
    .RNG_POLY  (POLY),
    .RNG_SEED  (SEED)
  ) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .variant_new_i (newer),
    .strap1_i      (strap1),
    .strap2_i      (strap2),
    .rev_i         (rev),
    .key_i         (key),
    .acc_en_i      (en),
    .acc_wr_i      (wr),
    .acc_addr_i    (addr),
    .acc_wdata_i   (wdata),
    .rd_data_o     (rd_data),
    .err_o         (err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [31:0] step(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? POLY : 32'h0);
  endfunction

  function automatic bit is_ro(input int ix);
    return ix == 5 || (ix >= 20 && ix <= 27) || ix == 30 || ix == 56 || ix == 57;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one access against the model; outputs checked one edge later
  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input string tag);
    logic [31:0] exp_rd;
    logic        exp_err;
    int          ix;
    ix      = int'(a[11:2]);
    exp_err = 1'b0;
    exp_rd  = last_rd;
    if (a[1:0] != 2'b00 || ix >= NREG) begin
      exp_err = 1'b1;
      if (!w) exp_rd = 32'h0;
    end else if (w) begin
      if (ix == 0)                   m[0] = (d == MAGIC) ? 32'h1 : 32'h0;
      else if (m[0] == 0 && ix < 65) exp_err = 1'b1;
      else if (is_ro(ix))            exp_err = 1'b1;
      else if (ix == 28)             m[28] = newer ? (m[28] | d) : d;
      else if (ix == 31) begin
        if (newer) m[28] = m[28] & ~d;
        else       exp_err = 1'b1;
      end else                       m[ix] = d;
    end else begin
      if (ix == 30) begin
        rng_m = step(rng_m);
        m[30] = rng_m;
      end
      exp_rd = m[ix];
      if (ix == 48) exp_err = 1'b1;
    end
    en = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0;
    chk({tag, " err"}, {31'h0, err}, {31'h0, exp_err});
    if (!w) chk({tag, " rdata"}, rd_data, exp_rd);
    last_rd = exp_rd;
  endtask

  task automatic raw_rd(input logic [11:0] a, output logic [31:0] v);
    en = 1'b1; wr = 1'b0; addr = a; wdata = 32'h0;
    @(negedge clk);
    en = 1'b0;
    v = rd_data;
    last_rd = v;
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk("R11 idle err", {31'h0, err}, 32'h0);
    chk("R11 rdata hold", rd_data, last_rd);
  endtask

  task automatic run_variant(input logic v);
    logic [31:0] val;
    newer  = v;
    strap1 = $urandom();
    strap2 = $urandom();
    rev    = $urandom();
    key    = v ? 32'h1 : 32'h0;
    en = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset rdata", rd_data, 32'h0);
    chk("R11 reset err", {31'h0, err}, 32'h0);
    rng_m = SEED;
    // R8: sweep reset state, capture model
    for (int i = 0; i < NREG; i++) begin
      if (i == 30) begin
        m[30] = 32'h0;
        acc(1'b0, 12'h078, 32'h0, "R7 first rng");
      end else begin
        raw_rd(12'(i * 4), val);
        m[i] = val;
      end
    end
    chk("R8 0x004", m[1], 32'hFFCF_FEDC);
    chk("R8 0x024", m[9], v ? 32'h9300_0400 : 32'h0000_0291);
    chk("R8 0x09C", m[39], v ? 32'h023F_FFF3 : 32'h003F_FFF3);
    chk("R8 0x1A4", m[105], 32'h0000_2402);
    chk("R8 0x100", m[64], 32'h0);
    chk("R8 key", m[0], key);
    chk("R8 strap1", m[28], strap1);
    chk("R8 strap2", m[52], strap2);
    chk("R8 rev", m[31], rev);

    // R2 and R3: lock, blocked write, unlock
    acc(1'b1, 12'h000, 32'h1234_5678, "R2 wrong key");
    acc(1'b0, 12'h000, 32'h0, "R2 key reads 0");
    acc(1'b1, 12'h008, 32'hDEAD_BEEF, "R3 locked write");
    acc(1'b0, 12'h008, 32'h0, "R3 locked word kept");
    acc(1'b1, 12'h100, 32'hAAAA_5555, "R3 locked 0x100");
    acc(1'b1, 12'h104, 32'h1357_9BDF, "R3 0x104 writable");
    acc(1'b0, 12'h104, 32'h0, "R3 0x104 readback");
    acc(1'b1, 12'h000, MAGIC, "R2 magic key");
    acc(1'b0, 12'h000, 32'h0, "R2 key reads 1");
    acc(1'b1, 12'h008, 32'hDEAD_BEEF, "R3 unlocked write");
    acc(1'b0, 12'h008, 32'h0, "R3 unlocked readback");
    idle_chk();
    // R4 read-only words
    acc(1'b1, 12'h014, 32'hFFFF_FFFF, "R4 ro 0x014");
    acc(1'b0, 12'h014, 32'h0, "R4 ro 0x014 kept");
    acc(1'b1, 12'h050, 32'h1111_1111, "R4 ro 0x050");
    acc(1'b1, 12'h06C, 32'h2222_2222, "R4 ro 0x06C");
    acc(1'b0, 12'h06C, 32'h0, "R4 ro 0x06C kept");
    acc(1'b1, 12'h0E4, 32'h3333_3333, "R4 ro 0x0E4");
    acc(1'b0, 12'h0E4, 32'h0, "R4 ro 0x0E4 kept");
    // R5 and R6 strap semantics
    acc(1'b1, 12'h070, 32'h0000_00F0, "R5 strap write a");
    acc(1'b1, 12'h070, 32'h0000_0F00, "R5 strap write b");
    acc(1'b0, 12'h070, 32'h0, "R5 strap value");
    acc(1'b1, 12'h07C, 32'h0000_0FF0, "R6 rev write");
    acc(1'b0, 12'h070, 32'h0, "R6 strap after rev write");
    acc(1'b0, 12'h07C, 32'h0, "R6 rev unchanged");
    // R7 rng independent of control enable
    acc(1'b1, 12'h074, 32'h0, "R7 rng ctl off");
    acc(1'b0, 12'h078, 32'h0, "R7 rng read 1");
    acc(1'b0, 12'h078, 32'h0, "R7 rng read 2");
    acc(1'b1, 12'h078, 32'h5555_AAAA, "R7 rng write ignored");
    acc(1'b0, 12'h078, 32'h0, "R7 rng read 3");
    // R10 wake-up word
    acc(1'b1, 12'h0C0, 32'hC0FF_EE00, "R10 wake write");
    acc(1'b0, 12'h0C0, 32'h0, "R10 wake read");
    idle_chk();
    // R1 misaligned and R9 out of range
    acc(1'b1, 12'h00A, 32'h9999_9999, "R1 misaligned write");
    acc(1'b0, 12'h009, 32'h0, "R1 misaligned read");
    acc(1'b0, 12'h008, 32'h0, "R1 word untouched");
    acc(1'b0, 12'h1A8, 32'h0, "R9 read past end");
    acc(1'b1, 12'hFFC, 32'h7777_7777, "R9 write past end");
    acc(1'b0, 12'h1A4, 32'h0, "R9 last word");
    idle_chk();

    // random traffic
    for (int k = 0; k < 1500; k++) begin
      int unsigned pick;
      logic [11:0] a;
      logic [31:0] d;
      logic        w;
      pick = $urandom_range(0, 99);
      w    = $urandom_range(0, 1) == 1;
      d    = $urandom();
      if (pick < 5)       a = 12'($urandom_range(0, 4095));
      else if (pick < 15) begin a = 12'h000; d = MAGIC; w = 1'b1; end
      else if (pick < 30) a = 12'(4 * $urandom_range(28, 31));
      else                a = 12'(4 * $urandom_range(0, 111));
      acc(w, a, d, "R1-model random");
    end
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    last_rd = 32'h0;
    void'($urandom(32'd7341));
    @(negedge clk);
    run_variant(1'b0);
    run_variant(1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule